// File: doc/BRIEF.md
# Priority Round-Robin Output Port Arbiter

One instance of this block sits in front of each output of a crossbar switch with eleven inputs. Every input raises a request line when it has a packet for this output, together with a flag that marks the packet as high or low priority. While the output is idle, the arbiter picks one requester and registers a one-hot grant. The grant then stays fixed until the packet's terminating byte has gone through. After that the output is idle for one cycle and a new round begins. Selection looks at the high-priority requesters first and falls back to the low-priority ones only when there are none. Inside the chosen level, the search starts at the input just above the previous owner and wraps around. This puts the previous owner last in line.

The arbiter does not see packet bytes. The crossbar reports each byte that moves on the output stream with a one-cycle `xfer` strobe, which means valid and ready were both high for that byte. It also raises `xfer_end` when that byte was an end marker. The arbiter applies no back-pressure of its own: a stalled destination or a stalled source simply shows up as cycles without `xfer`. When `wd_en` is set, a watchdog counts granted cycles that have no transfer. If that count reaches the selected interval, the output is released and `abort` pulses for one cycle, which tells the data path to close the cut packet with an error end marker. When `wd_en` is clear, blocking is allowed: a stalled owner keeps the output for as long as it stays stalled.

Top module: `oparb_top`

## Requirements
- R1: `grant` never has more than one bit set, and `busy` is high exactly when one bit of `grant` is set. Bit i of `grant` stands for input i.
- R2: When the output is idle and at least one `req` bit is high, `grant` selects one of the requesting inputs at the next rising clock edge.
- R3: Within a priority level, the search begins at the input numbered one above the previous owner and runs upward, wrapping from input N-1 to input 0.
- R4: An input that held the previous grant and is requesting again is granted only when no other input at the same level is requesting.
- R5: An input whose `req_hi` bit is 1 is granted before any input whose `req_hi` bit is 0, whatever its place in the rotation.
- R6: A grant holds until a clock edge at which `xfer` and `xfer_end` are both high. At that edge the grant clears. The output then stays idle for that cycle, and the next grant can appear one edge later at the earliest.
- R7: With `wd_en` = 1 and `wd_long` = 0, SHORT_TMO consecutive granted clock edges without `xfer` clear the grant, and `abort` is high for exactly the one following cycle.
- R8: A transfer that is not an end marker (`xfer` = 1, `xfer_end` = 0) restarts the watchdog interval in full.
- R9: With `wd_long` = 1, the interval is LONG_TMO edges instead of SHORT_TMO.
- R10: With `wd_en` = 0, a grant is never released by time and `abort` stays low.
- R11: If the end marker is transferred at the very edge at which the watchdog would have expired, the release is a normal one and `abort` stays low.
- R12: After reset, `grant` is zero and `busy` and `abort` are low. The previous owner is taken to be input N-1, so the first search starts at input 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| req | input | N_PORTS | Request for this output, one bit per input |
| req_hi | input | N_PORTS | Priority of each request, 1 = high |
| xfer | input | 1 | A byte moved on the output stream this cycle |
| xfer_end | input | 1 | The byte moved this cycle is an end marker |
| wd_en | input | 1 | 1 = watchdog mode, 0 = blocking allowed |
| wd_long | input | 1 | 1 = long timeout interval, 0 = short |
| grant | output | N_PORTS | One-hot grant of the output |
| busy | output | 1 | Output is owned by an input |
| abort | output | 1 | One-cycle pulse: owner cut off by the watchdog |

## Verification
Two events can land on the same clock edge: the end marker of the current packet and the expiry of the watchdog. The bench runs the watchdog until one edge before expiry and then presents the end marker on exactly the expiry edge. The correct result is a plain release with no abort pulse. A second pair is the rotation pointer against the priority filter. The bench places a low-priority requester directly after the previous owner and a high-priority requester further round, then checks that priority wins over position.

// File: rtl/oparb_pkg.sv
package oparb_pkg;
  typedef enum logic {
    LVL_LOW  = 1'b0,
    LVL_HIGH = 1'b1
  } level_e;

  localparam int unsigned DEF_PORTS = 11;
endpackage

// File: rtl/oparb_rr_pick.sv
module oparb_rr_pick #(
  parameter int unsigned N  = 11,
  parameter int unsigned IW = $clog2(N)
) (
  input  logic [N-1:0]  mask,
  input  logic [IW-1:0] last,
  output logic          hit,
  output logic [IW-1:0] idx
);
  int p;

  always_comb begin
    hit = 1'b0;
    idx = '0;
    p   = 0;
    for (int k = 1; k <= int'(N); k++) begin
      p = (int'(last) + k) % int'(N);
      if (!hit && mask[p]) begin
        hit = 1'b1;
        idx = IW'(p);
      end
    end
  end

  always_comb begin
    if (hit) AST_PICK_IS_REQ: assert (mask[idx]);  // R2
  end
endmodule

// File: rtl/oparb_wdog.sv
module oparb_wdog #(
  parameter int unsigned SHORT_TMO = 1024,
  parameter int unsigned LONG_TMO  = 65536,
  localparam int unsigned CW = $clog2(LONG_TMO + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wd_en,
  input  logic wd_long,
  input  logic busy,
  input  logic xfer,
  output logic expire
);
  logic [CW-1:0] cnt;
  logic [CW-1:0] limit_m1;

  assign limit_m1 = wd_long ? CW'(LONG_TMO - 1) : CW'(SHORT_TMO - 1);
  assign expire   = wd_en && busy && !xfer && (cnt >= limit_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                        cnt <= '0;
    else if (!busy || xfer || !wd_en)  cnt <= '0;
    else if (!expire)                  cnt <= cnt + 1'b1;
    else                               cnt <= '0;
  end

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    cnt < CW'(LONG_TMO));  // R7
  AST_XFER_RELOADS: assert property (@(posedge clk) disable iff (!rst_n)
    xfer |=> cnt == '0);  // R8
endmodule

// File: rtl/oparb_top.sv
module oparb_top
  import oparb_pkg::*;
#(
  parameter int unsigned N_PORTS   = DEF_PORTS,
  parameter int unsigned SHORT_TMO = 1024,
  parameter int unsigned LONG_TMO  = 65536,
  localparam int unsigned IW = $clog2(N_PORTS)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [N_PORTS-1:0] req,
  input  logic [N_PORTS-1:0] req_hi,
  input  logic               xfer,
  input  logic               xfer_end,
  input  logic               wd_en,
  input  logic               wd_long,
  output logic [N_PORTS-1:0] grant,
  output logic               busy,
  output logic               abort
);
  logic [IW-1:0] last_owner;
  logic [N_PORTS-1:0] mask_hi, mask_lo;
  logic hit_hi, hit_lo, expire, done;
  logic [IW-1:0] idx_hi, idx_lo, sel_idx;
  level_e sel_lvl;

  assign mask_hi = req & req_hi;
  assign mask_lo = req & ~req_hi;
  assign done    = busy && xfer && xfer_end;

  oparb_rr_pick #(.N(N_PORTS), .IW(IW)) u_pick_hi (
    .mask(mask_hi), .last(last_owner), .hit(hit_hi), .idx(idx_hi));
  oparb_rr_pick #(.N(N_PORTS), .IW(IW)) u_pick_lo (
    .mask(mask_lo), .last(last_owner), .hit(hit_lo), .idx(idx_lo));

  assign sel_lvl = hit_hi ? LVL_HIGH : LVL_LOW;
  assign sel_idx = (sel_lvl == LVL_HIGH) ? idx_hi : idx_lo;

  oparb_wdog #(.SHORT_TMO(SHORT_TMO), .LONG_TMO(LONG_TMO)) u_wdog (
    .clk(clk), .rst_n(rst_n), .wd_en(wd_en), .wd_long(wd_long),
    .busy(busy), .xfer(xfer), .expire(expire));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      grant      <= '0;
      busy       <= 1'b0;
      abort      <= 1'b0;
      last_owner <= IW'(N_PORTS - 1);
    end else begin
      abort <= 1'b0;
      if (busy) begin
        if (done) begin
          grant <= '0;
          busy  <= 1'b0;
        end else if (expire) begin
          grant <= '0;
          busy  <= 1'b0;
          abort <= 1'b1;
        end
      end else if (hit_hi || hit_lo) begin
        grant      <= {{(N_PORTS-1){1'b0}}, 1'b1} << sel_idx;
        busy       <= 1'b1;
        last_owner <= sel_idx;
      end
    end
  end

  AST_GRANT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(grant) && (busy == (grant != '0)));  // R1
  AST_GRANT_TO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && (req != '0) |=> busy && ((grant & $past(req)) != '0));  // R2
  AST_HI_FIRST: assert property (@(posedge clk) disable iff (!rst_n)
    !busy && ((req & req_hi) != '0) |=> (grant & $past(req & req_hi)) != '0);  // R5
  AST_GRANT_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !(xfer && xfer_end) |=> $stable(grant) || abort);  // R6
  AST_IDLE_AFTER_END: assert property (@(posedge clk) disable iff (!rst_n)
    busy && xfer && xfer_end |=> !busy && !abort);  // R11
  AST_NO_ABORT_BLOCKING: assert property (@(posedge clk) disable iff (!rst_n)
    !wd_en |=> !abort);  // R10
  AST_ABORT_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    abort |-> !busy && $past(busy));  // R7
endmodule

// File: tb/oparb_top_tb.sv
module oparb_top_tb;
  localparam int N = 11;
  localparam int SH = 6;
  localparam int LG = 20;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] req = '0, req_hi = '0;
  logic xfer = 1'b0, xfer_end = 1'b0, wd_en = 1'b0, wd_long = 1'b0;
  logic [N-1:0] grant;
  logic busy, abort;
  int n_chk = 0, n_fail = 0;

  always #5 clk = ~clk;

  oparb_top #(.N_PORTS(N), .SHORT_TMO(SH), .LONG_TMO(LG)) u_dut (
    .clk(clk), .rst_n(rst_n), .req(req), .req_hi(req_hi), .xfer(xfer),
    .xfer_end(xfer_end), .wd_en(wd_en), .wd_long(wd_long),
    .grant(grant), .busy(busy), .abort(abort));

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic step(input int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_pkt();
    xfer = 1'b1; xfer_end = 1'b1;
    step();
    xfer = 1'b0; xfer_end = 1'b0;
  endtask

  task automatic t_reset();
    chk("R12 grant", 32'(grant), 0);
    chk("R12 busy", 32'(busy), 0);
    chk("R12 abort", 32'(abort), 0);
  endtask

  task automatic t_rotation();
    req = (N'(1) << 2) | (N'(1) << 7);
    step();
    chk("R12 first search from 0", 32'(grant), 32'(N'(1) << 2));
    chk("R1 busy with grant", 32'(busy), 1);
    step(3);
    chk("R6 grant held", 32'(grant), 32'(N'(1) << 2));
    finish_pkt();
    chk("R6 released", 32'(busy), 0);
    step();
    chk("R3 next above owner", 32'(grant), 32'(N'(1) << 7));
    finish_pkt();
    step();
    chk("R3 wrap", 32'(grant), 32'(N'(1) << 2));
    req = (N'(1) << 2) | (N'(1) << 5);
    finish_pkt();
    step();
    chk("R3 from 3 up", 32'(grant), 32'(N'(1) << 5));
    req = (N'(1) << 5) | (N'(1) << 4);
    finish_pkt();
    step();
    chk("R4 last owner last", 32'(grant), 32'(N'(1) << 4));
    req = '0;
    finish_pkt();
  endtask

  task automatic t_priority();
    req    = (N'(1) << 5) | (N'(1) << 9);
    req_hi = N'(1) << 9;
    step();
    chk("R5 high first", 32'(grant), 32'(N'(1) << 9));
    req = '0; req_hi = '0;
    finish_pkt();
  endtask

  task automatic t_wdog_short();
    wd_en = 1'b1; wd_long = 1'b0;
    req = N'(1) << 1;
    step();
    req = '0;
    step(SH - 1);
    chk("R7 before expiry", 32'(busy), 1);
    step();
    chk("R7 released", 32'(busy), 0);
    chk("R7 abort pulse", 32'(abort), 1);
    step();
    chk("R7 abort one cycle", 32'(abort), 0);
  endtask

  task automatic t_wdog_reload();
    req = N'(1) << 3;
    step();
    req = '0;
    step(3);
    xfer = 1'b1;
    step();
    xfer = 1'b0;
    step(SH - 1);
    chk("R8 reloaded", 32'(busy), 1);
    step();
    chk("R8 expire after full interval", 32'(abort), 1);
    step();
  endtask

  task automatic t_wdog_long();
    wd_long = 1'b1;
    req = N'(1) << 6;
    step();
    req = '0;
    step(SH + 2);
    chk("R9 long not yet", 32'(busy), 1);
    step(LG - SH - 3);
    chk("R9 one before long", 32'(busy), 1);
    step();
    chk("R9 long expiry", 32'(abort), 1);
    wd_long = 1'b0;
    step();
  endtask

  task automatic t_blocking();
    bit seen_abort = 0;
    wd_en = 1'b0;
    req = N'(1) << 8;
    step();
    req = '0;
    for (int i = 0; i < 2 * LG; i++) begin
      step();
      if (abort) seen_abort = 1;
    end
    chk("R10 still owned", 32'(grant), 32'(N'(1) << 8));
    chk("R10 no abort", 32'(seen_abort), 0);
    finish_pkt();
  endtask

  task automatic t_collide();
    wd_en = 1'b1;
    req = N'(1) << 0;
    step();
    req = '0;
    step(SH - 1);
    chk("R11 owned before", 32'(busy), 1);
    finish_pkt();
    chk("R11 released", 32'(busy), 0);
    chk("R11 no abort", 32'(abort), 0);
    step();
    chk("R11 no late abort", 32'(abort), 0);
  endtask

  initial begin
    fork
      begin
        step(3);
        rst_n = 1'b1;
        step();
        t_reset();
        t_rotation();
        t_priority();
        t_wdog_short();
        t_wdog_reload();
        t_wdog_long();
        t_blocking();
        t_collide();
      end
      begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog expired actual=hung expected=done");
      end
    join_any
    disable fork;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule